// File: doc/BRIEF.md
# I2C Master Byte Engine

A single-master I2C controller operated by a host through four byte-wide registers: control, status, data and a stored own address. The host requests bus conditions by setting and clearing control bits. It moves data one byte at a time, and each data-register access is also a command. Writing the data register in transmit mode sends that byte. Reading the data register in receive mode returns the previously captured byte and clocks in the next one. Because of this, the first read after switching to receive returns a stale value and only serves to start the first reception.

The bus pins are open-drain. The block drives a "pull low" enable for each line and samples the resolved line levels. A single-cycle `tick` input from an external divider marks quarter-bit intervals, so every bit takes four ticks. Completion of a byte together with its acknowledge slot raises a sticky done flag. The level seen in the acknowledge slot is recorded as a not-acknowledged flag. A separate monitor watches the lines for START and STOP conditions and keeps a bus-busy flag.

Top module: `i2cm_engine`

## Requirements
- R1: After reset both line drivers are released and every register reads 0. The register addresses are: control at 0, status at 1, data at 2, own address at 3.
- R2: Control bit 0 enables the block and bit 1 requests bus ownership. When bit 1 is set, SDA is pulled low while SCL is high (START), and then SCL is pulled low. Status bit 2 (busy) reads 1 once a START has been seen on the lines.
- R3: With control bit 2 set to 1 (transmit), a data-register write sends that byte MSB first, followed by one acknowledge clock. Status bit 0 (done) sets when the acknowledge clock ends.
- R4: Status bit 1 holds the SDA level sampled in the acknowledge slot of the last byte. It reads 1 when no device pulled SDA low.
- R5: The done flag stays set until the host writes the status register with bit 0 equal to 0. A status write with bit 0 equal to 1 leaves it set.
- R6: With control bit 2 equal to 0 (receive), a data-register read returns the most recently received byte (0 if none) and starts reception of the next byte. A data-register read in transmit mode starts nothing.
- R7: In receive mode, control bit 3 selects the acknowledge slot level. When it is 0, the block pulls SDA low (ACK). When it is 1, the block leaves SDA released (NACK).
- R8: Setting control bit 4 while owning the bus produces a repeated START with no STOP before it. Bit 4 then clears itself.
- R9: Clearing control bit 1 while owning the bus produces a STOP: SDA rises while SCL is high. The busy flag then clears.
- R10: During a byte, SDA changes only while SCL is held low.
- R11: While control bit 0 is 0, both lines are released within one cycle, the sequencer returns to idle, any pending byte is dropped and busy reads 0. Setting bit 0 again allows a fresh transaction.
- R12: The control register (bits 3:0) and the own-address register read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Quarter-bit timing strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after reg_rd |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench uses the default DW of 8 and AW of 2. It pulses `tick` every fourth clock, so one byte with its acknowledge takes 144 cycles. That makes it practical to run complete transactions against a behavioural target on the resolved lines: address hits and misses, a write with a pointer byte, a repeated START into a read, ACK then NACK on received bytes, and an abort by disabling the block in the middle of a byte. Because the target logs every byte and acknowledge it observes, ordering on the bus and acknowledge levels are checked directly from the line side.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BYTE, ST_STOP, ST_RSTART
  } seq_e;

  // control register image, bit 0 = enable
  typedef struct packed {
    logic rsta;
    logic txak;
    logic tx;
    logic msta;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = 5;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          byte_done,
  input  logic          ack_level,
  input  logic [DW-1:0] rx_byte,
  input  logic          busy,
  input  logic          rsta_taken,
  output ctrl_t         ctrl_q,
  output logic [DW-1:0] tx_byte,
  output logic          launch,
  output logic          done_flag,
  output logic [DW-1:0] reg_rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);
  localparam logic [AW-1:0] A_OWN  = AW'(3);

  logic [DW-1:0] own_q;
  logic          nak_q;
  logic [DW-1:0] rd_mux;

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_mux = DW'(ctrl_q);
      A_STAT:  rd_mux = DW'({busy, nak_q, done_flag});
      A_DATA:  rd_mux = rx_byte;
      default: rd_mux = own_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      own_q     <= '0;
      tx_byte   <= '0;
      nak_q     <= 1'b0;
      done_flag <= 1'b0;
      launch    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      launch <= 1'b0;
      if (rsta_taken) ctrl_q.rsta <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
          A_STAT: if (!reg_wdata[0]) done_flag <= 1'b0;
          A_DATA: begin
            tx_byte <= reg_wdata;
            if (ctrl_q.en && ctrl_q.tx) launch <= 1'b1;
          end
          default: own_q <= reg_wdata;
        endcase
      end
      if (reg_rd) begin
        reg_rdata <= rd_mux;
        if (reg_addr == A_DATA && ctrl_q.en && !ctrl_q.tx) launch <= 1'b1;
      end
      // a completion event wins over a simultaneous clear
      if (byte_done) begin
        done_flag <= 1'b1;
        nak_q     <= ack_level;
      end
    end
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy
);
  logic scl_d, sda_d;
  logic start_seen, stop_seen;

  assign start_seen = scl_d & scl_i & sda_d & ~sda_i;
  assign stop_seen  = scl_d & scl_i & ~sda_d & sda_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
      if (!en)             busy <= 1'b0;
      else if (start_seen) busy <= 1'b1;
      else if (stop_seen)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  ctrl_t         ctrl,
  input  logic          launch,
  input  logic [DW-1:0] tx_byte,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          byte_done,
  output logic          ack_level,
  output logic [DW-1:0] rx_byte,
  output logic          rsta_taken,
  output logic          in_byte
);
  localparam int NBIT = DW + 1;
  localparam int BW   = $clog2(NBIT + 1);
  localparam logic [BW-1:0] LAST = BW'(NBIT - 1);
  localparam logic [BW-1:0] DWB  = BW'(DW);

  seq_e          st;
  logic [1:0]    q;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          pend, is_tx;

  assign in_byte = (st == ST_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; q <= '0; bitn <= '0; sh <= '0; pend <= 1'b0; is_tx <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; byte_done <= 1'b0; rsta_taken <= 1'b0;
      ack_level <= 1'b0; rx_byte <= '0;
    end else if (!ctrl.en) begin
      st <= ST_IDLE; q <= '0; bitn <= '0; pend <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; byte_done <= 1'b0; rsta_taken <= 1'b0;
    end else begin
      byte_done  <= 1'b0;
      rsta_taken <= 1'b0;
      if (launch && st != ST_BYTE) begin
        pend  <= 1'b1;
        is_tx <= ctrl.tx;
        sh    <= tx_byte;
      end
      if (tick) begin
        case (st)
          ST_IDLE: if (ctrl.msta) begin st <= ST_START; q <= '0; end
          ST_START: begin
            q <= q + 2'd1;
            if (q == 2'd0) sda_oe <= 1'b1;
            else begin scl_oe <= 1'b1; st <= ST_HOLD; end
          end
          ST_HOLD: begin
            q <= '0;
            if (!ctrl.msta)     st <= ST_STOP;
            else if (ctrl.rsta) st <= ST_RSTART;
            else if (pend) begin st <= ST_BYTE; bitn <= '0; pend <= 1'b0; end
          end
          ST_BYTE: begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_oe <= (bitn < DWB) ? (is_tx & ~sh[DW-1]) : (~is_tx & ~ctrl.txak);
              2'd1: scl_oe <= 1'b0;
              2'd2: if (bitn < DWB) sh <= {sh[DW-2:0], sda_i};
                    else ack_level <= sda_i;
              default: begin
                scl_oe <= 1'b1;
                if (bitn == LAST) begin
                  st <= ST_HOLD;
                  byte_done <= 1'b1;
                  if (!is_tx) rx_byte <= sh;
                end else bitn <= bitn + 1'b1;
              end
            endcase
          end
          ST_STOP: begin
            q <= q + 2'd1;
            case (q)
              2'd0:    sda_oe <= 1'b1;
              2'd1:    scl_oe <= 1'b0;
              default: begin sda_oe <= 1'b0; st <= ST_IDLE; end
            endcase
          end
          default: begin // ST_RSTART
            q <= q + 2'd1;
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin scl_oe <= 1'b1; st <= ST_HOLD; rsta_taken <= 1'b1; end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe
);
  ctrl_t         ctrl_q;
  logic          en_w;
  logic [DW-1:0] tx_byte, rx_byte;
  logic          launch, byte_done, ack_level, rsta_taken, busy, done_flag, in_byte;

  assign en_w = ctrl_q.en;

  i2cm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .byte_done(byte_done), .ack_level(ack_level),
    .rx_byte(rx_byte), .busy(busy), .rsta_taken(rsta_taken), .ctrl_q(ctrl_q),
    .tx_byte(tx_byte), .launch(launch), .done_flag(done_flag), .reg_rdata(reg_rdata)
  );

  i2cm_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl_q), .launch(launch),
    .tx_byte(tx_byte), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .byte_done(byte_done), .ack_level(ack_level), .rx_byte(rx_byte),
    .rsta_taken(rsta_taken), .in_byte(in_byte)
  );

  i2cm_busmon u_busmon (
    .clk(clk), .rst(rst), .en(en_w), .scl_i(scl_i), .sda_i(sda_i), .busy(busy)
  );
endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          scl_i,
  input logic          sda_i,
  input logic          busy,
  input logic          in_byte,
  input logic          byte_done,
  input logic          done_flag,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata
);
  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_oe && !sda_oe)); // R11

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_byte && $past(in_byte) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R10

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> done_flag); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !(reg_wr && reg_addr == AW'(1) && !reg_wdata[0])) |=> done_flag); // R5

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (en && $past(scl_i) && scl_i && $past(sda_i) && !sda_i) |=> busy); // R2

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !busy); // R9
endmodule

bind i2cm_engine i2cm_engine_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .en(en_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .scl_i(scl_i), .sda_i(sda_i), .busy(busy), .in_byte(in_byte),
  .byte_done(byte_done), .done_flag(done_flag), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/i2cm_engine_bench.sv
module i2cm_engine_bench;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] tcnt = 2'd0;
  logic tick;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic s_low;

  int checks = 0, fails = 0, cyc = 0;
  bit done_run = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd3);
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_low);

  i2cm_engine u_i2cm_engine (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // ---------------- behavioural target on the lines ----------------
  function automatic logic [7:0] rd_pat(input int i);
    return 8'hC3 ^ 8'(i * 37);
  endfunction

  logic ps = 1'b1, pd = 1'b1;
  int s_bit = 0, start_cnt = 0, stop_cnt = 0, wr_n = 0, rd_idx = 0, mack_n = 0;
  logic [7:0] s_sh = 8'd0, s_tx = 8'd0, last_wr = 8'd0;
  logic s_first = 0, s_sel = 0, s_rd = 0, s_mnak = 0;
  logic mack_log [0:3];

  initial s_low = 1'b0;

  always @(posedge clk) begin
    logic nl;
    nl = s_low;
    ps <= scl_line;
    pd <= sda_line;
    if (rst) begin
      nl = 1'b0; s_sel = 0; s_first = 0;
    end else if (ps && scl_line && pd && !sda_line) begin
      start_cnt++; s_bit = -1; s_first = 1; nl = 1'b0;
    end else if (ps && scl_line && !pd && sda_line) begin
      stop_cnt++; s_sel = 0; s_first = 0; nl = 1'b0;
    end else if (!ps && scl_line) begin
      if (s_bit >= 0 && s_bit < 8) s_sh = {s_sh[6:0], sda_line};
      else if (s_bit == 8 && !s_first && s_sel && s_rd) begin
        s_mnak = sda_line;
        if (mack_n < 4) mack_log[mack_n] = sda_line;
        mack_n++;
      end
    end else if (ps && !scl_line) begin
      s_bit++;
      if (s_bit == 8) begin
        if (s_first) nl = (s_sh[7:1] == SLV);
        else if (s_sel && !s_rd) begin nl = 1'b1; last_wr = s_sh; wr_n++; end
        else nl = 1'b0;
      end else if (s_bit == 9) begin
        s_bit = 0;
        if (s_first) begin
          s_first = 0; s_sel = (s_sh[7:1] == SLV); s_rd = s_sh[0]; s_mnak = 0;
        end else if (s_sel && s_rd && s_mnak) s_sel = 0;
        if (s_sel && s_rd) begin
          s_tx = rd_pat(rd_idx); rd_idx++; nl = !s_tx[7];
        end else nl = 1'b0;
      end else if (s_bit > 0 && s_sel && s_rd && !s_first) begin
        nl = !s_tx[7 - s_bit];
      end
    end
    s_low <= nl;
  end

  // ---------------- host helpers ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [7:0] s;
    s = 8'd0;
    for (int i = 0; i < 400; i++) begin
      rd(2'd1, s);
      if (s[0]) break;
    end
    chk(req, {7'd0, s[0]}, 8'd1);
  endtask

  task automatic wait_free(input string req);
    logic [7:0] s;
    s = 8'hFF;
    for (int i = 0; i < 400; i++) begin
      rd(2'd1, s);
      if (!s[2]) break;
    end
    chk(req, {7'd0, s[2]}, 8'd0);
  endtask

  // vector: {target address, data byte, expected nak on the address}
  localparam logic [15:0] VEC [5] = '{
    {7'h50, 8'hA5, 1'b0}, {7'h51, 8'h00, 1'b1}, {7'h50, 8'h3C, 1'b0},
    {7'h2A, 8'h7E, 1'b1}, {7'h50, 8'h81, 1'b0}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_run) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b0, b1;
    int sc, pc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", {7'd0, scl_oe}, 8'd0);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    rd(2'd3, v); chk("R1 own", v, 8'h00);
    // R12 readback
    wr(2'd3, 8'hA4); rd(2'd3, v); chk("R12 own", v, 8'hA4);
    wr(2'd0, 8'h0D); rd(2'd0, v); chk("R12 ctrl", v, 8'h0D);
    wr(2'd0, 8'h05);

    // table of write transactions
    for (int k = 0; k < 5; k++) begin
      logic [6:0] ta; logic [7:0] td; logic en_;
      {ta, td, en_} = VEC[k];
      wr(2'd0, 8'h07);
      repeat (20) @(negedge clk);
      rd(2'd1, v); chk("R2 busy after start", {7'd0, v[2]}, 8'd1);
      wr(2'd2, {ta, 1'b0});
      wait_done("R3 address done");
      rd(2'd1, v); chk("R4 address nak", {7'd0, v[1]}, {7'd0, en_});
      wr(2'd1, 8'h00);
      if (!en_) begin
        pc = wr_n;
        wr(2'd2, td);
        wait_done("R3 data done");
        rd(2'd1, v); chk("R4 data ack", {7'd0, v[1]}, 8'd0);
        chk("R3 byte seen by target", last_wr, td);
        chk("R3 one byte logged", 8'(wr_n - pc), 8'd1);
        wr(2'd1, 8'h00);
      end
      sc = stop_cnt;
      wr(2'd0, 8'h05);
      wait_free("R9 busy clears after stop");
      chk("R9 stop seen", 8'(stop_cnt - sc), 8'd1);
    end

    // R5 sticky done flag
    wr(2'd0, 8'h07);
    wr(2'd2, 8'hA0);
    wait_done("R5 setup");
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R5 write 1 keeps done", {7'd0, v[0]}, 8'd1);
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk("R5 still set", {7'd0, v[0]}, 8'd1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R5 write 0 clears", {7'd0, v[0]}, 8'd0);

    // pointer byte, then repeated start into a read
    wr(2'd2, 8'h10);
    wait_done("R3 pointer");
    wr(2'd1, 8'h00);
    sc = start_cnt; pc = stop_cnt;
    wr(2'd0, 8'h17);
    wr(2'd2, 8'hA1);
    wait_done("R8 read address");
    chk("R8 one extra start", 8'(start_cnt - sc), 8'd1);
    chk("R8 no stop", 8'(stop_cnt - pc), 8'd0);
    rd(2'd0, v); chk("R8 restart bit self-clears", {7'd0, v[4]}, 8'd0);
    rd(2'd1, v); chk("R8 busy held", {7'd0, v[2]}, 8'd1);
    chk("R4 read address ack", {7'd0, v[1]}, 8'd0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03);
    rd(2'd2, v); chk("R6 dummy read", v, 8'h00);
    wait_done("R6 first receive");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0B);
    rd(2'd2, b0); chk("R6 first byte", b0, rd_pat(0));
    wait_done("R6 second receive");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0D);
    wait_free("R9 stop after read");
    rd(2'd2, b1); chk("R6 second byte", b1, rd_pat(1));
    chk("R7 ack on first", {7'd0, mack_log[0]}, 8'd0);
    chk("R7 nack on last", {7'd0, mack_log[1]}, 8'd1);
    repeat (200) @(negedge clk);
    rd(2'd1, v); chk("R6 tx-mode read starts nothing", {7'd0, v[0]}, 8'd0);
    chk("R6 target not clocked", 8'(mack_n), 8'd2);

    // R11 abort by disable mid-byte
    wr(2'd0, 8'h07);
    wr(2'd2, 8'hA0);
    repeat (60) @(negedge clk);
    wr(2'd0, 8'h06);
    @(negedge clk);
    chk("R11 scl released", {7'd0, scl_oe}, 8'd0);
    chk("R11 sda released", {7'd0, sda_oe}, 8'd0);
    rd(2'd1, v); chk("R11 busy cleared", {7'd0, v[2]}, 8'd0);
    repeat (100) @(negedge clk);
    chk("R11 stays released", {6'd0, scl_oe, sda_oe}, 8'd0);
    wr(2'd0, 8'h07);
    wr(2'd2, 8'hA0);
    wait_done("R11 recovery");
    rd(2'd1, v); chk("R11 recovery ack", {7'd0, v[1]}, 8'd0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    wait_free("R9 final stop");

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule